// File: doc/BRIEF.md
# Status Byte Service Request Logic

This block forms an eight-bit instrument status byte from six live summary lines and raises a service request toward a host. The summary bits are not stored. Each one tracks its input in the same cycle. A host-writable enable byte selects which status bits may contribute to a master summary bit. That bit is the OR of every status bit ANDed with its enable bit.

Two read views of the status byte are exposed. The status-query view carries the master summary in bit 6. The serial-poll view carries a latched request-for-service flag in bit 6, and a poll strobe clears that flag. The flag is set by a rising edge of the master summary and drives the active-high service request output. Event registers, queues and bus handshaking sit outside the block and appear here only as input wires and a read strobe.

Top module: `srq_status_top`

## Requirements
- R1: While rst_ni is low and after its release, the enable readback is 0x00, srq_o is low, and bit 6 of the poll view is 0.
- R2: A write (en_wr_i high at a clock edge) loads en_wdata_i into the enable byte. Bit 6 is stored as 0, so writing 0xFF reads back 0xBF and writing 0x5A reads back 0x1A.
- R3: In both read views, status bit 0 equals meas_sum_i, bit 2 equals err_avail_i, bit 3 equals quest_sum_i, bit 4 equals msg_avail_i, bit 5 equals evt_sum_i and bit 7 equals oper_sum_i. Each bit follows its input in the same cycle, with no latching.
- R4: Bit 1 is 0 in both read views for every input pattern.
- R5: Bit 6 of the status-query view is the OR over bits 0 to 5 and bit 7 of (status bit AND enable bit). Enable bit 6 has no effect.
- R6: One clock edge after the master summary rises from 0 to 1, the request flag is set and srq_o is high. Before that edge, srq_o stays low.
- R7: Bit 6 of the poll view shows the request flag. A clock edge with poll_i high clears the flag, so srq_o is low from that edge on.
- R8: After a poll clears the flag, it stays clear while the master summary stays high. It sets again only after the master summary falls and then rises.
- R9: If the master summary rises in the same cycle as a poll, the flag is set after the edge, so the new request is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_sum_i | input | 1 | Measurement summary line |
| err_avail_i | input | 1 | Error-available summary line |
| quest_sum_i | input | 1 | Questionable summary line |
| msg_avail_i | input | 1 | Message-available summary line |
| evt_sum_i | input | 1 | Standard event summary line |
| oper_sum_i | input | 1 | Operation summary line |
| en_wr_i | input | 1 | Enable byte write strobe |
| en_wdata_i | input | 8 | Enable byte write data |
| en_rdata_o | output | 8 | Enable byte readback |
| query_rdata_o | output | 8 | Status-query view, master summary in bit 6 |
| poll_i | input | 1 | Serial poll read strobe, clears the request flag |
| poll_rdata_o | output | 8 | Serial-poll view, request flag in bit 6 |
| srq_o | output | 1 | Service request output, active high |

## Verification
The bench uses the package defaults: an eight-bit byte and the fixed bit map, with bit 6 as the special position. With these values it can walk every summary line to its own position, with enable bit 6 both set and clear. It can also place a master-summary rising edge exactly on a poll cycle. That makes the edge-triggered set, the clear on poll, and their collision all visible at the srq_o and poll-view ports.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned STB_W   = 8;
  localparam int unsigned B_MEAS  = 0;
  localparam int unsigned B_RSVD  = 1;
  localparam int unsigned B_ERR   = 2;
  localparam int unsigned B_QUEST = 3;
  localparam int unsigned B_MSG   = 4;
  localparam int unsigned B_EVT   = 5;
  localparam int unsigned B_SUMM  = 6;
  localparam int unsigned B_OPER  = 7;

  typedef logic [STB_W-1:0] stb_t;

  typedef struct packed {
    logic meas;
    logic err;
    logic quest;
    logic msg;
    logic evt;
    logic oper;
  } sum_lines_t;

  localparam stb_t SUMM_MASK = stb_t'(1) << B_SUMM;
  localparam stb_t RSVD_MASK = stb_t'(1) << B_RSVD;
endpackage

// File: rtl/srq_enable_reg.sv
module srq_enable_reg
  import srq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  stb_t wdata_i,
  output stb_t en_o
);
  stb_t en_q;

  // summary position is never enabled, always reads 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & ~SUMM_MASK;
  end

  assign en_o = en_q;

  p_write_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_q == ($past(wdata_i) & ~SUMM_MASK)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q));
endmodule

// File: rtl/srq_status_assemble.sv
module srq_status_assemble
  import srq_pkg::*;
(
  input  sum_lines_t lines_i,
  input  stb_t       en_i,
  output stb_t       stb_o,
  output logic       mss_o
);
  stb_t stb;

  always_comb begin
    stb          = '0;
    stb[B_MEAS]  = lines_i.meas;
    stb[B_ERR]   = lines_i.err;
    stb[B_QUEST] = lines_i.quest;
    stb[B_MSG]   = lines_i.msg;
    stb[B_EVT]   = lines_i.evt;
    stb[B_OPER]  = lines_i.oper;
  end

  assign stb_o = stb;
  // summary position excluded from both operands
  assign mss_o = |(stb & en_i & ~SUMM_MASK);

  always_comb begin
    a_rsvd_zero_r4: assert (stb_o[B_RSVD] == 1'b0);
    a_summ_free_r5: assert (stb_o[B_SUMM] == 1'b0);
  end
endmodule

// File: rtl/srq_rqs_ctrl.sv
module srq_rqs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mss_i,
  input  logic poll_i,
  output logic rqs_o
);
  logic mss_q, rqs_q, rise;

  assign rise = mss_i & ~mss_q;

  // a new rising edge outranks a poll clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss_i;
      if (rise)        rqs_q <= 1'b1;
      else if (poll_i) rqs_q <= 1'b0;
    end
  end

  assign rqs_o = rqs_q;

  p_set_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mss_i) |=> rqs_q);
  p_poll_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !$rose(mss_i)) |=> !rqs_q);
  p_no_spurious_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rqs_q && !$rose(mss_i)) |=> !rqs_q);
endmodule

// File: rtl/srq_status_top.sv
module srq_status_top
  import srq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_sum_i,
  input  logic             err_avail_i,
  input  logic             quest_sum_i,
  input  logic             msg_avail_i,
  input  logic             evt_sum_i,
  input  logic             oper_sum_i,
  input  logic             en_wr_i,
  input  logic [STB_W-1:0] en_wdata_i,
  output logic [STB_W-1:0] en_rdata_o,
  output logic [STB_W-1:0] query_rdata_o,
  input  logic             poll_i,
  output logic [STB_W-1:0] poll_rdata_o,
  output logic             srq_o
);
  sum_lines_t lines;
  stb_t       en, stb;
  logic       mss, rqs;

  assign lines = '{meas: meas_sum_i, err: err_avail_i, quest: quest_sum_i,
                   msg: msg_avail_i, evt: evt_sum_i, oper: oper_sum_i};

  srq_enable_reg u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (en_wr_i),
    .wdata_i(en_wdata_i),
    .en_o   (en)
  );

  srq_status_assemble u_asm (
    .lines_i(lines),
    .en_i   (en),
    .stb_o  (stb),
    .mss_o  (mss)
  );

  srq_rqs_ctrl u_rqs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mss_i (mss),
    .poll_i(poll_i),
    .rqs_o (rqs)
  );

  assign en_rdata_o    = en;
  assign query_rdata_o = stb | (stb_t'(mss) << B_SUMM);
  assign poll_rdata_o  = stb | (stb_t'(rqs) << B_SUMM);
  assign srq_o         = rqs;

  p_srq_poll_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srq_o == poll_rdata_o[B_SUMM]);
  p_views_agree_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_rdata_o & ~SUMM_MASK) == (poll_rdata_o & ~SUMM_MASK));
  p_en_summ_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rdata_o[B_SUMM] == 1'b0);
endmodule

// File: tb/sim_srq_status_top.sv
module sim_srq_status_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       meas = 0, err = 0, quest = 0, msg = 0, evt = 0, oper = 0;
  logic       en_wr = 0, poll = 0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata, q_rdata, p_rdata;
  logic       srq;
  int         checks = 0, failures = 0;
  logic [7:0] en_model = '0;

  always #10 clk_i = ~clk_i;

  srq_status_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .meas_sum_i(meas), .err_avail_i(err), .quest_sum_i(quest),
    .msg_avail_i(msg), .evt_sum_i(evt), .oper_sum_i(oper),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .en_rdata_o(en_rdata),
    .query_rdata_o(q_rdata), .poll_i(poll), .poll_rdata_o(p_rdata),
    .srq_o(srq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // bit map: 0 meas, 2 err, 3 quest, 4 msg, 5 evt, 7 oper
  function automatic logic [7:0] stb_model();
    return {oper, 1'b0, evt, msg, quest, err, 1'b0, meas};
  endfunction

  function automatic logic mss_model();
    return |(stb_model() & en_model & 8'hBF);
  endfunction

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic set_lines(input logic [5:0] v);
    {oper, evt, msg, quest, err, meas} = v;
  endtask

  task automatic write_en(input logic [7:0] v);
    @(negedge clk_i);
    en_wr = 1; en_wdata = v;
    @(negedge clk_i);
    en_wr = 0; en_model = v & 8'hBF; #1;
  endtask

  task automatic do_poll();
    @(negedge clk_i);
    poll = 1;
    @(negedge clk_i);
    poll = 0; #1;
  endtask

  task automatic t_reset();
    #5;
    chk("R1 en in reset", en_rdata, 8'h00);
    chk("R1 srq in reset", {7'b0, srq}, 8'h00);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    step();
    chk("R1 en after reset", en_rdata, 8'h00);
    chk("R1 srq after reset", {7'b0, srq}, 8'h00);
    chk("R1 poll bit6", {7'b0, p_rdata[6]}, 8'h00);
  endtask

  task automatic t_enable();
    write_en(8'hFF);
    chk("R2 write FF", en_rdata, 8'hBF);
    write_en(8'h5A);
    chk("R2 write 5A", en_rdata, 8'h1A);
    write_en(8'h00);
    chk("R2 write 00", en_rdata, 8'h00);
  endtask

  task automatic t_map();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      set_lines(6'(1) << i); #1;
      chk("R3 query map", q_rdata, stb_model());
      chk("R3 poll map", p_rdata, stb_model());
      set_lines(6'h00); #1;
      chk("R3 no latch", q_rdata, 8'h00);
    end
    @(negedge clk_i);
    set_lines(6'h3F); #1;
    chk("R4 query bit1", {7'b0, q_rdata[1]}, 8'h00);
    chk("R4 poll bit1", {7'b0, p_rdata[1]}, 8'h00);
    set_lines(6'h00);
  endtask

  task automatic t_mss();
    write_en(8'h40);
    @(negedge clk_i);
    set_lines(6'h3F); #1;
    chk("R5 enable bit6 ignored", {7'b0, q_rdata[6]}, 8'h00);
    step();
    chk("R5 no srq from bit6", {7'b0, srq}, 8'h00);
    write_en(8'h20);
    set_lines(6'h00); #1;
    chk("R5 mss low", {7'b0, q_rdata[6]}, {7'b0, mss_model()});
    step();
    evt = 1; #1;
    chk("R5 mss evt", {7'b0, q_rdata[6]}, 8'h01);
    chk("R6 srq before edge", {7'b0, srq}, 8'h00);
    step();
    chk("R6 srq set", {7'b0, srq}, 8'h01);
    chk("R7 poll view bit6", {7'b0, p_rdata[6]}, 8'h01);
    do_poll();
    chk("R7 cleared", {7'b0, srq}, 8'h00);
    repeat (3) step();
    chk("R8 stays clear", {7'b0, srq}, 8'h00);
    evt = 0; step();
    chk("R8 after fall", {7'b0, srq}, 8'h00);
    evt = 1; step();
    chk("R8 reset on new rise", {7'b0, srq}, 8'h01);
  endtask

  task automatic t_collide();
    evt = 0; step();
    chk("R9 still set", {7'b0, srq}, 8'h01);
    evt = 1; poll = 1; #1;
    chk("R9 poll bit6 read", {7'b0, p_rdata[6]}, 8'h01);
    @(negedge clk_i); poll = 0; #1;
    chk("R9 set wins", {7'b0, srq}, 8'h01);
    do_poll();
    chk("R9 later poll clears", {7'b0, srq}, 8'h00);
    evt = 0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_map();
    t_mss();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule